// File: doc/BRIEF.md
# Prioritized Atomic Register-Update Controller

Two signed registers, `x` and `y`, are updated by a small set of guarded processes. Each process has its own request input. When granted, a process applies a fixed change to one register or to both. A process is atomic: in a given cycle it applies all of its changes or none of them. When two requesting processes would write the same register, the one ranked higher in a configurable order wins. The loser is suppressed for that cycle on every register, including registers the winner does not touch.

The block comes in two variants, chosen by a parameter: a three-process set and a four-process set. A packed priority parameter lists process indices from highest rank to lowest. Arbitration is derived from that list and from each process's write set, so reordering priorities needs no change to the update logic. A per-process `fired_o` bit shows, in the same cycle as the request, which processes are granted. Their changes land on the next rising clock edge.

Top module: `prio_update_ctrl`

## Requirements
- R1: A synchronous active-low reset clears `x_o` and `y_o` to zero at the clock edge where `rst_n` is low. While `rst_n` is low, `fired_o` is all zeros.
- R2: Process 0 (request bit 0) adds 1 to `x` and leaves `y` unchanged.
- R3: Process 1 (request bit 1) subtracts 1 from `x` and adds 1 to `y` at the same edge.
- R4: Process 2 (request bit 2) subtracts 1 from `y`. In the four-process variant it also adds 1 to `x`. In the three-process variant `x` is unchanged.
- R5: Process 3 (request bit 3, four-process variant only) adds 2 to `x` and subtracts 2 from `y`.
- R6: A requesting process is granted only if no higher-ranked granted process writes a register that it also writes. A suppressed process changes neither register. The default order from highest rank is 2, 3, 1, 0 for four processes. The three-process bench instance uses 2, 1, 0.
- R7: Requesting processes whose write sets do not overlap are granted in the same cycle. For example, in the three-process variant processes 2 and 0 both apply.
- R8: `fired_o[p]` is high, combinationally in the request cycle, exactly when process p is granted. Its changes appear on `x_o`/`y_o` after the next rising edge.
- R9: Both registers are 16-bit two's complement by default and wrap on overflow and underflow.
- R10: With no process granted, `x_o` and `y_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cond_i | input | NUM_PROC | Request bit per process, bit p for process p |
| x_o | output | WIDTH | Register x, signed |
| y_o | output | WIDTH | Register y, signed |
| fired_o | output | NUM_PROC | Grant per process in the current cycle |

## Verification
A wrong grant appears on `fired_o` in the very cycle the requests are presented. The corrupted register value follows one edge later. A broken atomicity rule shows as a lone change to one register while the other stays put, for example `x` moving without `y` after a suppressed transfer. Once a bad value enters `x` or `y` it persists, because every later update is relative. A single wrong step is therefore visible in every following check, and the bench compares both registers after every edge it drives.

// File: rtl/upd_pkg.sv
package upd_pkg;

   typedef logic [3:0][1:0] prio_t;

   // change applied to x by process p; process 2 touches x only in the four-process set
   function automatic int step_x(input int p, input int nproc);
      case (p)
         0: return 1;
         1: return -1;
         2: return (nproc == 4) ? 1 : 0;
         3: return 2;
         default: return 0;
      endcase
   endfunction

   function automatic int step_y(input int p);
      case (p)
         1: return 1;
         2: return -1;
         3: return -2;
         default: return 0;
      endcase
   endfunction

   // the first nproc entries must be a permutation of 0..nproc-1
   function automatic bit prio_valid(input prio_t order, input int nproc);
      logic [3:0] seen;
      seen = '0;
      for (int r = 0; r < nproc; r++) begin
         if (int'(order[r]) >= nproc) return 1'b0;
         if (seen[order[r]]) return 1'b0;
         seen[order[r]] = 1'b1;
      end
      return 1'b1;
   endfunction

endpackage

// File: rtl/upd_effect.sv
module upd_effect
   import upd_pkg::*;
#(
   parameter int WIDTH    = 16,
   parameter int NUM_PROC = 4
) (
   output logic [NUM_PROC-1:0]            wr_x_o,
   output logic [NUM_PROC-1:0]            wr_y_o,
   output logic [NUM_PROC-1:0][WIDTH-1:0] dx_o,
   output logic [NUM_PROC-1:0][WIDTH-1:0] dy_o
);
   for (genvar p = 0; p < NUM_PROC; p++) begin : g_proc
      localparam int SX = step_x(p, NUM_PROC);
      localparam int SY = step_y(p);
      assign wr_x_o[p] = (SX != 0);
      assign wr_y_o[p] = (SY != 0);
      assign dx_o[p]   = WIDTH'(SX);
      assign dy_o[p]   = WIDTH'(SY);
   end
endmodule

// File: rtl/upd_arbiter.sv
module upd_arbiter
   import upd_pkg::*;
#(
   parameter int    NUM_PROC = 4,
   parameter prio_t PRIO     = {2'd0, 2'd1, 2'd3, 2'd2}
) (
   input  logic [NUM_PROC-1:0] req_i,
   input  logic [NUM_PROC-1:0] wr_x_i,
   input  logic [NUM_PROC-1:0] wr_y_i,
   output logic [NUM_PROC-1:0] grant_o
);
   logic x_taken;
   logic y_taken;

   // walk the ranks top-down; a process wins only if all its registers are still free
   always_comb begin
      grant_o = '0;
      x_taken = 1'b0;
      y_taken = 1'b0;
      for (int r = 0; r < NUM_PROC; r++) begin
         if (req_i[PRIO[r]] &&
             !(wr_x_i[PRIO[r]] && x_taken) &&
             !(wr_y_i[PRIO[r]] && y_taken)) begin
            grant_o[PRIO[r]] = 1'b1;
            x_taken = x_taken | wr_x_i[PRIO[r]];
            y_taken = y_taken | wr_y_i[PRIO[r]];
         end
      end
   end
endmodule

// File: rtl/upd_regs.sv
module upd_regs #(
   parameter int WIDTH    = 16,
   parameter int NUM_PROC = 4
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_PROC-1:0]            grant_i,
   input  logic [NUM_PROC-1:0][WIDTH-1:0] dx_i,
   input  logic [NUM_PROC-1:0][WIDTH-1:0] dy_i,
   output logic [WIDTH-1:0]               x_q,
   output logic [WIDTH-1:0]               y_q
);
   logic [WIDTH-1:0] sum_x;
   logic [WIDTH-1:0] sum_y;

   // at most one granted writer per register, so the sum is that writer's delta
   always_comb begin
      sum_x = '0;
      sum_y = '0;
      for (int p = 0; p < NUM_PROC; p++) begin
         if (grant_i[p]) begin
            sum_x = sum_x + dx_i[p];
            sum_y = sum_y + dy_i[p];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         x_q <= '0;
         y_q <= '0;
      end else begin
         x_q <= x_q + sum_x;
         y_q <= y_q + sum_y;
      end
   end
endmodule

// File: rtl/prio_update_ctrl.sv
module prio_update_ctrl
   import upd_pkg::*;
#(
   parameter int    WIDTH    = 16,
   parameter int    NUM_PROC = 4,
   parameter prio_t PRIO     = {2'd0, 2'd1, 2'd3, 2'd2}
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_PROC-1:0]      cond_i,
   output logic signed [WIDTH-1:0]  x_o,
   output logic signed [WIDTH-1:0]  y_o,
   output logic [NUM_PROC-1:0]      fired_o
);
   localparam bit ORDER_OK = prio_valid(PRIO, NUM_PROC);

   if (NUM_PROC != 3 && NUM_PROC != 4) begin : g_bad_nproc
      $error("prio_update_ctrl: NUM_PROC must be 3 or 4");
   end
   if (!ORDER_OK) begin : g_bad_prio
      $error("prio_update_ctrl: PRIO is not a permutation of the processes");
   end
   if (WIDTH < 3) begin : g_bad_width
      $error("prio_update_ctrl: WIDTH must hold a step of 2");
   end

   logic [NUM_PROC-1:0]            req;
   logic [NUM_PROC-1:0]            grant;
   logic [NUM_PROC-1:0]            wr_x;
   logic [NUM_PROC-1:0]            wr_y;
   logic [NUM_PROC-1:0][WIDTH-1:0] dx;
   logic [NUM_PROC-1:0][WIDTH-1:0] dy;
   logic [WIDTH-1:0]               x_q;
   logic [WIDTH-1:0]               y_q;

   assign req = rst_n ? cond_i : '0;

   upd_effect #(.WIDTH(WIDTH), .NUM_PROC(NUM_PROC)) u_effect (
      .wr_x_o (wr_x),
      .wr_y_o (wr_y),
      .dx_o   (dx),
      .dy_o   (dy)
   );

   upd_arbiter #(.NUM_PROC(NUM_PROC), .PRIO(PRIO)) u_arb (
      .req_i   (req),
      .wr_x_i  (wr_x),
      .wr_y_i  (wr_y),
      .grant_o (grant)
   );

   upd_regs #(.WIDTH(WIDTH), .NUM_PROC(NUM_PROC)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .grant_i (grant),
      .dx_i    (dx),
      .dy_i    (dy),
      .x_q     (x_q),
      .y_q     (y_q)
   );

   assign x_o     = x_q;
   assign y_o     = y_q;
   assign fired_o = grant;
endmodule

// File: rtl/upd_checker.sv
module upd_checker
   import upd_pkg::*;
#(
   parameter int    WIDTH    = 16,
   parameter int    NUM_PROC = 4,
   parameter prio_t PRIO     = {2'd0, 2'd1, 2'd3, 2'd2}
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [NUM_PROC-1:0]     cond_i,
   input logic signed [WIDTH-1:0] x_o,
   input logic signed [WIDTH-1:0] y_o,
   input logic [NUM_PROC-1:0]     fired_o
);
   logic [NUM_PROC-1:0] xmask;
   logic [NUM_PROC-1:0] ymask;
   for (genvar p = 0; p < NUM_PROC; p++) begin : g_mask
      assign xmask[p] = (step_x(p, NUM_PROC) != 0);
      assign ymask[p] = (step_y(p) != 0);
   end

   AST_RESET_CLEARS: assert property (@(posedge clk)
      !rst_n |=> (x_o == '0 && y_o == '0)); // R1
   AST_P0_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      fired_o == NUM_PROC'(1) |=> (x_o == $past(x_o) + WIDTH'(1) && y_o == $past(y_o))); // R2
   AST_P1_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
      fired_o == NUM_PROC'(2) |=> (x_o == $past(x_o) - WIDTH'(1) && y_o == $past(y_o) + WIDTH'(1))); // R3
   AST_ONE_X_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(fired_o & xmask) <= 1); // R6
   AST_ONE_Y_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(fired_o & ymask) <= 1); // R6
   AST_TOP_RANK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      cond_i[PRIO[0]] |-> fired_o[PRIO[0]]); // R6
   AST_FIRED_NEEDS_COND: assert property (@(posedge clk) disable iff (!rst_n)
      (fired_o & ~cond_i) == '0); // R8
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      fired_o == '0 |=> ($stable(x_o) && $stable(y_o))); // R10
endmodule

bind prio_update_ctrl upd_checker #(.WIDTH(WIDTH), .NUM_PROC(NUM_PROC), .PRIO(PRIO)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .cond_i  (cond_i),
   .x_o     (x_o),
   .y_o     (y_o),
   .fired_o (fired_o)
);

// File: tb/tb_prio_update_ctrl.sv
`timescale 1ns/1ps
module tb_prio_update_ctrl;
   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [3:0]         cond4 = '0;
   logic [2:0]         cond3 = '0;
   logic signed [15:0] x4, y4, x3, y3;
   logic [3:0]         f4;
   logic [2:0]         f3;
   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   prio_update_ctrl dut (
      .clk(clk), .rst_n(rst_n), .cond_i(cond4), .x_o(x4), .y_o(y4), .fired_o(f4));

   prio_update_ctrl #(.NUM_PROC(3), .PRIO({2'd0, 2'd0, 2'd1, 2'd2})) dut3 (
      .clk(clk), .rst_n(rst_n), .cond_i(cond3), .x_o(x3), .y_o(y3), .fired_o(f3));

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // present requests after a falling edge, sample the grants, then the registers after the edge
   task automatic drive(input logic [3:0] c4, input logic [2:0] c3);
      @(negedge clk);
      cond4 = c4;
      cond3 = c3;
      #1;
   endtask

   task automatic edge_pass();
      @(posedge clk);
      #1;
   endtask

   task automatic step4(input string req, input logic [3:0] c, input int ef, input int ex, input int ey);
      drive(c, 3'b000);
      chk({req, " fired"}, int'(f4), ef);
      edge_pass();
      chk({req, " x"}, int'(x4), ex);
      chk({req, " y"}, int'(y4), ey);
   endtask

   task automatic step3(input string req, input logic [2:0] c, input int ef, input int ex, input int ey);
      drive(4'b0000, c);
      chk({req, " fired"}, int'(f3), ef);
      edge_pass();
      chk({req, " x"}, int'(x3), ex);
      chk({req, " y"}, int'(y3), ey);
   endtask

   task automatic t_reset();
      drive(4'b1111, 3'b111);
      chk("R1 fired in reset", int'(f4), 0);
      edge_pass();
      chk("R1 x after reset", int'(x4), 0);
      chk("R1 y after reset", int'(y4), 0);
      drive(4'b0000, 3'b000);
      rst_n = 1'b1;
   endtask

   task automatic t_idle();
      step4("R10 idle", 4'b0000, 0, 0, 0);
      step4("R10 idle again", 4'b0000, 0, 0, 0);
   endtask

   task automatic t_singles();
      step4("R2 p0", 4'b0001, 1, 1, 0);
      step4("R3 p1", 4'b0010, 2, 0, 1);
      step4("R4 p2 ext", 4'b0100, 4, 1, 0);
      step4("R5 p3", 4'b1000, 8, 3, -2);
   endtask

   task automatic t_priority();
      step4("R6 all four", 4'b1111, 4, 4, -3);
      step4("R6 p3 over p1,p0", 4'b1011, 8, 6, -5);
      step4("R6 p1 over p0 atomic", 4'b0011, 2, 5, -4);
      step4("R8 fired cleared", 4'b0000, 0, 5, -4);
   endtask

   task automatic t_wrap();
      drive(4'b1000, 3'b000);
      for (int i = 0; i < 16381; i++) edge_pass();
      chk("R9 x at max", int'(x4), 32767);
      chk("R9 y near min", int'(y4), -32766);
      step4("R9 x overflow", 4'b0001, 1, -32768, -32766);
      step4("R9 y to min", 4'b1000, 8, -32766, -32768);
      step4("R9 y underflow", 4'b1000, 8, -32764, 32766);
   endtask

   task automatic t_midreset();
      drive(4'b1111, 3'b000);
      rst_n = 1'b0;
      #0.1;
      chk("R1 fired gated", int'(f4), 0);
      edge_pass();
      chk("R1 x cleared", int'(x4), 0);
      chk("R1 y cleared", int'(y4), 0);
      drive(4'b0000, 3'b000);
      rst_n = 1'b1;
   endtask

   task automatic t_base();
      step3("R7 p2 with p0", 3'b111, 5, 1, -1);
      step3("R4 p2 base leaves x", 3'b100, 4, 1, -2);
      step3("R6 base p1 over p0", 3'b011, 2, 0, -1);
   endtask

   initial begin
      t_reset();
      t_idle();
      t_singles();
      t_priority();
      t_wrap();
      t_midreset();
      t_base();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule